// File: doc/BRIEF.md
# I2C Slave Engine with Address Recognition

This block is the target side of an I2C port. It watches the two bus lines through synchronizers and picks START and STOP conditions out of them. After each START it collects the first byte and checks it against a programmable 7-bit own address. If enabled, it also checks it against the general-call address. It then answers with an acknowledge or stays silent.

Once selected, it moves one byte at a time as a receiver or as a transmitter. After every byte it publishes an 8-bit status code and raises an interrupt flag. While that flag is up it holds the clock line low, so software can read the received byte or supply the next one before clearing the flag. There is no master side and no clock generator.

Software controls the engine through a few level inputs and two one-cycle pulses. The level inputs are: enable, acknowledge-enable, general-call enable, own address and transmit byte. The pulses are: clear the interrupt flag, and force an internal stop. Clearing acknowledge-enable detaches the engine from address matching but leaves it watching the bus. The engine follows whatever clock rate the external master uses.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, irq, scl_pull, sda_pull and stop_flag are 0 and status reads F8h (no information).
- R2: When an address byte with bits [7:1] equal to own_addr and bit 0 = 0 (write) arrives while ack_en = 1, the engine pulls SDA low for the ninth clock. It then sets irq with status 60h. If bit 0 = 1 (read), status is A8h.
- R3: The address byte 00h is acknowledged with status 70h only when gc_en = 1 and ack_en = 1. With gc_en = 0 it gets no acknowledge and irq stays 0.
- R4: An address byte that does not match, or any address byte seen while ack_en = 0, gets no acknowledge. irq stays 0 and status keeps its value.
- R5: ack_en is sampled only at the end of the address byte. Setting it after some address bits have already passed still lets a matching address be acknowledged.
- R6: In receiver mode, each data byte appears on rx_byte and is acknowledged while ack_en = 1, giving status 80h (90h after a general call). With ack_en = 0 the byte gets no acknowledge and status is 88h (98h). The engine is then no longer addressed: later bytes get no acknowledge, and a STOP raises no irq.
- R7: In transmitter mode, tx_byte is loaded when irq is cleared and driven MSB first. A master acknowledge with ack_en = 1 gives status B8h. A master not-acknowledge gives status C0h.
- R8: If ack_en = 0 when the master acknowledges a sent byte, status is C8h. After irq is cleared, SDA is left released and the engine is no longer addressed.
- R9: A STOP or a repeated START while addressed sets irq with status A0h. After a repeated START, a new address byte is matched normally.
- R10: While irq = 1 and enable = 1, the engine holds SCL low once SCL has gone low. It releases SCL after irq is cleared and never starts pulling SCL while the line is high.
- R11: A stop_req pulse sets stop_flag for exactly one cycle and drives nothing on the bus. The engine becomes not addressed: the following data byte gets no acknowledge and raises no irq.
- R12: With enable = 0 both line pulls are released within one cycle, stop_flag is cleared, and the engine is no longer addressed once re-enabled.
- R13: The engine only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 = pull SCL low (open drain) |
| sda_pull | output | 1 | 1 = pull SDA low (open drain) |
| enable | input | 1 | Engine enable |
| ack_en | input | 1 | Acknowledge / address-match enable |
| gc_en | input | 1 | Accept general-call address 00h |
| own_addr | input | 7 | Own 7-bit address |
| stop_req | input | 1 | One-cycle pulse: force internal stop |
| si_ack | input | 1 | One-cycle pulse: clear irq (loads tx_byte in transmitter mode) |
| tx_byte | input | 8 | Next byte to transmit |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| rx_byte | output | 8 | Last received byte |
| stop_flag | output | 1 | Forced-stop request pending |

## Verification
The bench drives a master model on wired-AND lines and targets several corner cases:
- Acknowledge-enable is raised halfway through an address byte. A design that latched it at START would miss the match.
- A data byte is refused. A design that stayed addressed afterwards would acknowledge the next byte or report A0h at the STOP.
- The last transmitted byte is acknowledged with acknowledge-enable low. A design that kept driving SDA, or that let go of SCL before irq was cleared, is caught with the master releasing SCL.
- General call with its enable off, a repeated START in the middle of a transfer, the forced stop, and disabling the engine while it stretches the clock are each checked at the pins.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_END
  } phase_t;

  typedef struct packed {
    logic scl;
    logic sda;
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_ev_t;

  localparam logic [7:0] ST_NONE     = 8'hF8;
  localparam logic [7:0] ST_SLA_W    = 8'h60;
  localparam logic [7:0] ST_GCALL    = 8'h70;
  localparam logic [7:0] ST_RX_ACK   = 8'h80;
  localparam logic [7:0] ST_RX_NACK  = 8'h88;
  localparam logic [7:0] ST_GRX_ACK  = 8'h90;
  localparam logic [7:0] ST_GRX_NACK = 8'h98;
  localparam logic [7:0] ST_END_BUS  = 8'hA0;
  localparam logic [7:0] ST_SLA_R    = 8'hA8;
  localparam logic [7:0] ST_TX_ACK   = 8'hB8;
  localparam logic [7:0] ST_TX_NACK  = 8'hC0;
  localparam logic [7:0] ST_TX_LAST  = 8'hC8;

endpackage

// File: rtl/i2c_line_sync.sv
// Two bus lines through a flop chain each, then START/STOP/edge events.
module i2c_line_sync #(
  parameter int STAGES = 2   // must be 2 or more
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output i2c_slv_pkg::bus_ev_t ev
);
  localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] raw;
  wire  [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end

  always_comb begin
    ev.scl   = cur[0];
    ev.sda   = cur[1];
    ev.rise  = cur[0] & ~prev[0];
    ev.fall  = ~cur[0] & prev[0];
    ev.start = cur[0] & prev[0] & prev[1] & ~cur[1];
    ev.stop  = cur[0] & prev[0] & ~prev[1] & cur[1];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
// Byte engine: address match, receive, transmit, status and clock hold.
module i2c_slave_fsm #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  i2c_slv_pkg::bus_ev_t ev,
  input  logic                 enable,
  input  logic                 ack_en,
  input  logic                 gc_en,
  input  logic [DATA_W-2:0]    own_addr,
  input  logic                 stop_req,
  input  logic                 si_ack,
  input  logic [DATA_W-1:0]    tx_byte,
  output logic                 si,
  output logic [7:0]           status,
  output logic [DATA_W-1:0]    rx_byte,
  output logic                 stop_flag,
  output logic                 sda_pull,
  output logic                 scl_pull
);
  import i2c_slv_pkg::*;

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W);

  phase_t            phase;
  logic [BIT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] txsh;
  logic              gcall;
  logic              rd_dir;
  logic              mack;
  logic              own_hit;
  logic              gc_hit;
  logic              addressed;

  always_comb begin
    own_hit   = ack_en && (sh[DATA_W-1:1] == own_addr);
    gc_hit    = ack_en && gc_en && (sh == '0);
    addressed = (phase == PH_AACK) || (phase == PH_RX) || (phase == PH_RACK) ||
                (phase == PH_TX) || (phase == PH_TACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      txsh      <= '0;
      gcall     <= 1'b0;
      rd_dir    <= 1'b0;
      mack      <= 1'b0;
      si        <= 1'b0;
      status    <= ST_NONE;
      rx_byte   <= '0;
      stop_flag <= 1'b0;
      sda_pull  <= 1'b0;
      scl_pull  <= 1'b0;
    end else begin
      scl_pull <= enable & si & ~ev.scl;
      if (si_ack) si <= 1'b0;

      if (!enable || stop_flag) begin
        phase     <= PH_IDLE;
        sda_pull  <= 1'b0;
        stop_flag <= 1'b0;
        cnt       <= '0;
      end else begin
        if (stop_req) stop_flag <= 1'b1;
        if (ev.start || ev.stop) begin
          sda_pull <= 1'b0;
          cnt      <= '0;
          if (addressed) begin
            si     <= 1'b1;
            status <= ST_END_BUS;
          end
          phase <= ev.start ? PH_ADDR : PH_IDLE;
        end else begin
          unique case (phase)
            PH_ADDR: begin
              if (ev.rise) begin
                sh  <= {sh[DATA_W-2:0], ev.sda};
                cnt <= cnt + 1'b1;
              end else if (ev.fall && cnt == LAST) begin
                if (own_hit || gc_hit) begin
                  sda_pull <= 1'b1;
                  gcall    <= gc_hit & ~own_hit;
                  rd_dir   <= own_hit & sh[0];
                  phase    <= PH_AACK;
                end else begin
                  phase <= PH_IDLE;
                end
              end
            end
            PH_AACK: begin
              if (ev.fall) begin
                sda_pull <= 1'b0;
                si       <= 1'b1;
                cnt      <= '0;
                status   <= gcall ? ST_GCALL : (rd_dir ? ST_SLA_R : ST_SLA_W);
                phase    <= rd_dir ? PH_TX : PH_RX;
              end
            end
            PH_RX: begin
              if (ev.rise) begin
                sh  <= {sh[DATA_W-2:0], ev.sda};
                cnt <= cnt + 1'b1;
              end else if (ev.fall && cnt == LAST) begin
                rx_byte  <= sh;
                sda_pull <= ack_en;
                mack     <= ack_en;
                phase    <= PH_RACK;
              end
            end
            PH_RACK: begin
              if (ev.fall) begin
                sda_pull <= 1'b0;
                si       <= 1'b1;
                cnt      <= '0;
                if (gcall) status <= mack ? ST_GRX_ACK : ST_GRX_NACK;
                else       status <= mack ? ST_RX_ACK : ST_RX_NACK;
                phase <= mack ? PH_RX : PH_IDLE;
              end
            end
            PH_TX: begin
              if (si_ack && si && cnt == '0) begin
                txsh     <= tx_byte;
                sda_pull <= ~tx_byte[DATA_W-1];
              end else if (ev.rise) begin
                cnt <= cnt + 1'b1;
              end else if (ev.fall && cnt != '0) begin
                if (cnt == LAST) begin
                  sda_pull <= 1'b0;
                  phase    <= PH_TACK;
                end else begin
                  txsh     <= txsh << 1;
                  sda_pull <= ~txsh[DATA_W-2];
                end
              end
            end
            PH_TACK: begin
              if (ev.rise) begin
                mack <= ~ev.sda;
              end else if (ev.fall) begin
                si  <= 1'b1;
                cnt <= '0;
                if (!mack) begin
                  status <= ST_TX_NACK;
                  phase  <= PH_END;
                end else if (ack_en) begin
                  status <= ST_TX_ACK;
                  phase  <= PH_TX;
                end else begin
                  status <= ST_TX_LAST;
                  phase  <= PH_END;
                end
              end
            end
            PH_END: begin
              if (si_ack && si) phase <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              enable,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stop_req,
  input  logic              si_ack,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              irq,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_byte,
  output logic              stop_flag
);
  i2c_slv_pkg::bus_ev_t ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  i2c_slave_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .enable    (enable),
    .ack_en    (ack_en),
    .gc_en     (gc_en),
    .own_addr  (own_addr),
    .stop_req  (stop_req),
    .si_ack    (si_ack),
    .tx_byte   (tx_byte),
    .si        (irq),
    .status    (status),
    .rx_byte   (rx_byte),
    .stop_flag (stop_flag),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull)
  );
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_in,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       enable,
  input logic       irq,
  input logic       stop_flag,
  input logic [7:0] status
);
  // R10
  scl_hold_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    scl_pull |-> $past(irq));

  // R10
  scl_hold_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> !$past(scl_in));

  // R13
  sda_drive_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !$past(scl_in));

  // R11
  stop_flag_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_flag |=> !stop_flag);

  // R12
  disable_release_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sda_pull && !scl_pull));

  // R2
  irq_has_status_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (status != 8'hF8));
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_in    (scl_in),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull),
  .enable    (enable),
  .irq       (irq),
  .stop_flag (stop_flag),
  .status    (status)
);

// File: tb/i2c_addr_slave_bench.sv
module i2c_addr_slave_bench;
  localparam int H = 8;  // half bit period in clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  wire        scl_line, sda_line;
  logic       scl_pull, sda_pull;
  logic       enable = 1'b1, ack_en = 1'b1, gc_en = 1'b0;
  logic [6:0] own_addr = 7'h2C;
  logic       stop_req = 1'b0, si_ack = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       irq, stop_flag;
  logic [7:0] status, rx_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_addr_slave u_i2c_addr_slave (
    .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .enable(enable),
    .ack_en(ack_en), .gc_en(gc_en), .own_addr(own_addr),
    .stop_req(stop_req), .si_ack(si_ack), .tx_byte(tx_byte),
    .irq(irq), .status(status), .rx_byte(rx_byte), .stop_flag(stop_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hw(H); scl_up(); hw(H);
    sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hw(H); scl_up(); hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; hw(H); scl_up(); hw(H); scl_m = 1'b0; hw(H/2);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; hw(H); scl_up(); hw(H/2); b = sda_line; hw(H/2);
    scl_m = 1'b0; hw(H/2);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    acked = ~b;
    hw(3);
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(~give_ack);
    hw(3);
  endtask

  task automatic si_clr();
    si_ack = 1'b1; @(negedge clk); si_ack = 1'b0; hw(2);
  endtask

  // expected status after an address byte, F8 = not selected
  function automatic logic [7:0] exp_addr(input logic [7:0] ab, input logic [6:0] own,
                                          input logic gce, input logic aa);
    if (!aa) return 8'hF8;
    if (ab[7:1] == own) return ab[0] ? 8'hA8 : 8'h60;
    if (ab == 8'h00 && gce) return 8'h70;
    return 8'hF8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    logic       ak;
    logic [7:0] d;
    logic [7:0] last_st;
    void'($urandom(32'd4711));
    hw(4); rst = 1'b0; hw(2);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 status", status, 8'hF8);
    chk("R1 pulls", {scl_pull, sda_pull}, 0);
    chk("R1 stop_flag", stop_flag, 0);

    // R4 own address while ack_en low
    ack_en = 1'b0;
    m_start(); m_wbyte({own_addr, 1'b0}, ak);
    chk("R4 no ack", ak, 0);
    chk("R4 no irq", irq, 0);
    chk("R4 status kept", status, 8'hF8);
    m_stop();
    // R4 other address with ack_en high
    ack_en = 1'b1;
    m_start(); m_wbyte({7'h11, 1'b0}, ak);
    chk("R4 mismatch no ack", ak, 0);
    chk("R4 mismatch no irq", irq, 0);
    m_stop();

    // R5 ack_en raised mid address
    ack_en = 1'b0;
    m_start();
    for (int i = 7; i >= 4; i--) m_wbit(own_addr[i-1]);
    ack_en = 1'b1;
    for (int i = 3; i >= 1; i--) m_wbit(own_addr[i-1]);
    m_wbit(1'b0);
    m_rbit(ak); ak = ~ak; hw(3);
    chk("R5 late ack", ak, 1);
    chk("R5 status", status, 8'h60);
    si_clr();
    m_stop(); hw(2);
    chk("R9 stop irq", irq, 1);
    chk("R9 stop status", status, 8'hA0);
    si_clr();

    // R3 general call disabled, then enabled
    gc_en = 1'b0;
    m_start(); m_wbyte(8'h00, ak);
    chk("R3 gc off no ack", ak, 0);
    chk("R3 gc off no irq", irq, 0);
    m_stop();
    gc_en = 1'b1;
    m_start(); m_wbyte(8'h00, ak);
    chk("R3 gc ack", ak, 1);
    chk("R3 gc status", status, 8'h70);
    si_clr();
    m_wbyte(8'hC3, ak);
    chk("R6 gc data ack", ak, 1);
    chk("R6 gc data status", status, 8'h90);
    chk("R6 gc rx", rx_byte, 8'hC3);
    si_clr();
    ack_en = 1'b0;
    m_wbyte(8'h3C, ak);
    chk("R6 gc data nack", ak, 0);
    chk("R6 gc nack status", status, 8'h98);
    si_clr();
    ack_en = 1'b1;
    m_stop(); hw(2);
    chk("R6 gc released no irq", irq, 0);
    gc_en = 1'b0;

    // R6 own write, data refused
    m_start(); m_wbyte({own_addr, 1'b0}, ak);
    chk("R2 own write ack", ak, 1);
    chk("R2 own write status", status, 8'h60);
    si_clr();
    ack_en = 1'b0;
    m_wbyte(8'hA5, ak);
    chk("R6 nack", ak, 0);
    chk("R6 nack status", status, 8'h88);
    chk("R6 nack rx", rx_byte, 8'hA5);
    si_clr();
    ack_en = 1'b1;
    m_wbyte(8'h5A, ak);
    chk("R6 later byte ignored", ak, 0);
    chk("R6 later no irq", irq, 0);
    m_stop(); hw(2);
    chk("R6 stop no irq", irq, 0);

    // R8 transmitter, last byte with ack_en low, plus R10 stretch
    m_start(); m_wbyte({own_addr, 1'b1}, ak);
    chk("R2 own read ack", ak, 1);
    chk("R2 own read status", status, 8'hA8);
    tx_byte = 8'h96; ack_en = 1'b0;
    si_clr();
    m_rbyte(d, 1'b1);
    chk("R7 tx data", d, 8'h96);
    chk("R8 last status", status, 8'hC8);
    sda_m = 1'b1; hw(2);
    scl_m = 1'b1; hw(40);
    chk("R10 scl held", scl_line, 0);
    chk("R10 scl_pull", scl_pull, 1);
    si_clr(); hw(4);
    chk("R10 scl released", scl_line, 1);
    chk("R8 sda released", sda_line, 1);
    scl_m = 1'b0; hw(H);
    ack_en = 1'b1;
    m_stop(); hw(2);
    chk("R8 not addressed stop", irq, 0);

    // R9 repeated start while addressed
    m_start(); m_wbyte({own_addr, 1'b0}, ak);
    si_clr();
    m_wbyte(8'h42, ak);
    chk("R6 data status", status, 8'h80);
    si_clr();
    m_start(); hw(2);
    chk("R9 rs irq", irq, 1);
    chk("R9 rs status", status, 8'hA0);
    si_clr();
    m_wbyte({own_addr, 1'b0}, ak);
    chk("R9 readdress ack", ak, 1);
    chk("R9 readdress status", status, 8'h60);
    si_clr();
    m_stop(); si_clr();

    // R11 forced internal stop
    m_start(); m_wbyte({own_addr, 1'b0}, ak);
    si_clr();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    chk("R11 flag set", stop_flag, 1);
    @(negedge clk);
    chk("R11 flag cleared", stop_flag, 0);
    chk("R11 bus untouched", {scl_line, sda_line}, 2'b01);
    m_wbyte(8'h77, ak);
    chk("R11 no ack", ak, 0);
    chk("R11 no irq", irq, 0);
    m_stop();

    // R12 disable while stretching
    m_start(); m_wbyte({own_addr, 1'b0}, ak);
    hw(2);
    chk("R10 stretching", scl_pull, 1);
    enable = 1'b0; hw(2);
    chk("R12 pulls released", {scl_pull, sda_pull}, 0);
    si_clr(); enable = 1'b1; hw(2);
    m_wbyte(8'h19, ak);
    chk("R12 no ack", ak, 0);
    chk("R12 no irq", irq, 0);
    m_stop();

    // random transactions
    for (int t = 0; t < 16; t++) begin
      logic [7:0] ab;
      logic [7:0] ex;
      int sel, nb;
      own_addr = 7'($urandom_range(1, 127));
      gc_en = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 3);
      nb = $urandom_range(1, 3);
      if (sel == 0)      ab = {own_addr, 1'b0};
      else if (sel == 1) ab = {own_addr, 1'b1};
      else if (sel == 2) ab = 8'h00;
      else begin
        logic [6:0] o;
        do o = 7'($urandom_range(1, 127)); while (o == own_addr);
        ab = {o, 1'($urandom_range(0, 1))};
      end
      ex = exp_addr(ab, own_addr, gc_en, ack_en);
      last_st = status;
      m_start(); m_wbyte(ab, ak);
      chk("R2 rnd ack", ak, ex != 8'hF8);
      if (ex == 8'hF8) begin
        chk("R4 rnd no irq", irq, 0);
        chk("R4 rnd status kept", status, last_st);
        m_stop();
      end else begin
        chk("R2 rnd status", status, ex);
        if (ex == 8'hA8) begin
          for (int k = 0; k < nb; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            tx_byte = v;
            si_clr();
            m_rbyte(d, k != nb - 1);
            chk("R7 rnd tx data", d, v);
            chk("R7 rnd tx status", status, (k != nb - 1) ? 8'hB8 : 8'hC0);
          end
          si_clr();
          m_stop(); hw(2);
          chk("R7 rnd stop after nack", irq, 0);
        end else begin
          si_clr();
          for (int k = 0; k < nb; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            m_wbyte(v, ak);
            chk("R6 rnd ack", ak, 1);
            chk("R6 rnd rx", rx_byte, v);
            chk("R6 rnd status", status, (ex == 8'h70) ? 8'h90 : 8'h80);
            si_clr();
          end
          m_stop(); hw(2);
          chk("R9 rnd stop", status, 8'hA0);
          si_clr();
        end
      end
    end

    report();
    $finish;
  end
endmodule